// File: doc/BRIEF.md
# Tagged Branch Target Predictor

The block sits beside the fetch stage of a pipelined processor. Every cycle it takes the current fetch address, looks it up in a direct-mapped table of branch entries, and returns the address to fetch next within the same cycle. A recorded branch whose 2-bit direction counter leans taken sends fetch to the stored target. A lookup that misses, or that hits a counter leaning not-taken, falls through to the sequential address, fetch address plus 4.

Address bits [1:0] are always zero for aligned instructions, so they take no part in the lookup. The next `IDX_W` bits select the entry. All bits above those form a tag, which must match in full before a stored target is used, so that two branches sharing an index cannot steer each other.

When a branch resolves later in the pipeline, the update port delivers its address, its real target and whether it was taken. A taken branch claims its entry and a not-taken one never does. The direction counters saturate in both directions. As a build-time option, the counter index is the entry index XORed with a register of recent outcomes, so that the same branch can predict differently depending on the path that led to it.

Top module: `btb_predictor`

## Requirements
- R1: After reset every lookup misses: `pred_hit`=0, `pred_taken`=0 and `pred_next_pc` = `fetch_pc`+4, until a taken resolution is written.
- R2: The entry index is PC[IDX_W+1:2] and the tag is PC[PC_W-1:IDX_W+2]. PC[1:0] plays no part in the lookup. With PC_W=32 and IDX_W=10, address 0x001CA810 uses index 0x204 and tag 0x001CA.
- R3: A hit needs a valid entry whose stored tag equals the lookup tag. A lookup at the same index with another tag misses and falls through to PC+4.
- R4: On a predicted-taken hit, `pred_next_pc` equals the stored target in the same cycle as `fetch_pc`. In every other case it equals `fetch_pc`+4.
- R5: Counter encoding: 0 = strong not-taken, 1 = weak not-taken, 2 = weak taken, 3 = strong taken. The prediction is taken when the counter is 2 or 3. A resolution that hits counts up when taken, saturating at 3, and counts down when not taken, saturating at 0.
- R6: A taken resolution that misses allocates the entry. It writes the tag and the target, sets the valid bit, and sets the selected counter to 2 (weak taken).
- R7: A taken resolution that hits replaces the stored target with the resolved one.
- R8: A not-taken resolution that misses changes no entry and no counter.
- R9: While `upd_valid` is 0, the `upd_*` inputs change nothing.
- R10: With USE_GHR=1, the counter index is the entry index XOR the zero-extended HIST_W-bit history. Each valid resolution shifts the history left and inserts the outcome at bit 0. The history is 0 after reset. A resolution uses the history as it stood before its own shift.
- R11: A resolution presented in a cycle becomes visible to lookups from the next cycle on. A lookup in the same cycle sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| pred_hit | output | 1 | Valid entry with matching tag |
| pred_taken | output | 1 | Hit and counter leans taken |
| pred_next_pc | output | PC_W | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_target | input | PC_W | Actual target of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
Every piece of internal state surfaces on the lookup outputs one cycle after the write that set it. A corrupted valid bit or tag shows as a wrong hit on the next lookup of that index. A wrong target shows as a wrong predicted address. A counter that steps wrongly may stay hidden while the other counter values predict the same direction. It is exposed at the latest when the counter should cross the taken/not-taken boundary, which the loop and alternating branch streams force within a few resolutions. In the history-indexed variant, a history register that shifts wrongly sends later lookups to the wrong counter, and the mismatch appears within HIST_W resolutions.

// File: rtl/btb_pkg.sv
package btb_pkg;

   typedef enum logic [1:0] {
      CTR_STRONG_NT = 2'b00,
      CTR_WEAK_NT   = 2'b01,
      CTR_WEAK_T    = 2'b10,
      CTR_STRONG_T  = 2'b11
   } ctr_t;

   // saturating step of a direction counter
   function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
      ctr_t n;
      n = c;
      if (taken) begin
         case (c)
            CTR_STRONG_NT: n = CTR_WEAK_NT;
            CTR_WEAK_NT:   n = CTR_WEAK_T;
            default:       n = CTR_STRONG_T;
         endcase
      end else begin
         case (c)
            CTR_STRONG_T: n = CTR_WEAK_T;
            CTR_WEAK_T:   n = CTR_WEAK_NT;
            default:      n = CTR_STRONG_NT;
         endcase
      end
      return n;
   endfunction

   function automatic logic ctr_says_taken(input ctr_t c);
      return c[1];
   endfunction

endpackage

// File: rtl/btb_index.sv
module btb_index #(
   parameter int PC_W    = 32,
   parameter int IDX_W   = 10,
   parameter int HIST_W  = 4,
   parameter bit USE_GHR = 1'b0,
   localparam int TAG_W  = PC_W - IDX_W - 2
) (
   input  logic [PC_W-1:0]   pc,
   input  logic [HIST_W-1:0] hist,
   output logic [IDX_W-1:0]  idx,
   output logic [IDX_W-1:0]  cidx,
   output logic [TAG_W-1:0]  tag
);

   logic unused_low;
   assign unused_low = ^pc[1:0];

   assign idx = pc[IDX_W+1:2];
   assign tag = pc[PC_W-1:IDX_W+2];

   generate
      if (USE_GHR) begin : g_hashed
         assign cidx = idx ^ IDX_W'(hist);
      end else begin : g_plain
         logic unused_hist;
         assign unused_hist = ^hist;
         assign cidx = idx;
      end
   endgenerate

endmodule

// File: rtl/btb_history.sv
module btb_history #(
   parameter int HIST_W  = 4,
   parameter bit USE_GHR = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              outcome,
   output logic [HIST_W-1:0] hist
);

   generate
      if (USE_GHR) begin : g_reg
         logic [HIST_W-1:0] hist_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        hist_q <= '0;
            else if (shift_en) hist_q <= (hist_q << 1) | HIST_W'(outcome);
         end
         assign hist = hist_q;
      end else begin : g_none
         logic unused_in;
         assign unused_in = shift_en ^ outcome ^ clk ^ rst_n;
         assign hist = '0;
      end
   endgenerate

endmodule

// File: rtl/btb_store.sv
module btb_store
   import btb_pkg::*;
#(
   parameter int PC_W     = 32,
   parameter int IDX_W    = 10,
   localparam int ENTRIES = 1 << IDX_W,
   localparam int TAG_W   = PC_W - IDX_W - 2,
   localparam int TGT_W   = PC_W - 2
) (
   input  logic             clk,
   input  logic             rst_n,
   // lookup side
   input  logic [IDX_W-1:0] rd_idx,
   input  logic [IDX_W-1:0] rd_cidx,
   input  logic [TAG_W-1:0] rd_tag,
   output logic             rd_hit,
   output logic             rd_taken,
   output logic [PC_W-1:0]  rd_target,
   // resolution side
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [IDX_W-1:0] wr_cidx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic             wr_taken,
   input  logic [PC_W-1:0]  wr_target
);

   logic [ENTRIES-1:0] valid_q;
   logic [TAG_W-1:0]   tag_q [ENTRIES];
   logic [TGT_W-1:0]   tgt_q [ENTRIES];
   ctr_t               ctr_q [ENTRIES];

   logic unused_tgt_low;
   assign unused_tgt_low = ^wr_target[1:0];

   // lookup: pure read of registered contents
   assign rd_hit    = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
   assign rd_taken  = rd_hit && ctr_says_taken(ctr_q[rd_cidx]);
   assign rd_target = {tgt_q[rd_idx], 2'b00};

   logic wr_hit;
   assign wr_hit = valid_q[wr_idx] && (tag_q[wr_idx] == wr_tag);

   // valid bits and counters carry reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= CTR_WEAK_NT;
      end else if (wr_en) begin
         if (wr_taken) begin
            valid_q[wr_idx] <= 1'b1;
            ctr_q[wr_cidx]  <= wr_hit ? ctr_step(ctr_q[wr_cidx], 1'b1) : CTR_WEAK_T;
         end else if (wr_hit) begin
            ctr_q[wr_cidx]  <= ctr_step(ctr_q[wr_cidx], 1'b0);
         end
      end
   end

   // tag and target storage needs no reset: guarded by valid_q
   always_ff @(posedge clk) begin
      if (wr_en && wr_taken) begin
         tag_q[wr_idx] <= wr_tag;
         tgt_q[wr_idx] <= wr_target[PC_W-1:2];
      end
   end

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor #(
   parameter int PC_W    = 32,
   parameter int IDX_W   = 10,
   parameter int HIST_W  = 4,
   parameter bit USE_GHR = 1'b0,
   localparam int TAG_W  = PC_W - IDX_W - 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] fetch_pc,
   output logic            pred_hit,
   output logic            pred_taken,
   output logic [PC_W-1:0] pred_next_pc,
   input  logic            upd_valid,
   input  logic [PC_W-1:0] upd_pc,
   input  logic [PC_W-1:0] upd_target,
   input  logic            upd_taken
);

   generate
      if (IDX_W < 1 || IDX_W > 16) begin : g_bad_idx
         $error("btb_predictor: IDX_W must lie in 1..16");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("btb_predictor: PC_W leaves no tag bits");
      end
      if (HIST_W < 1 || HIST_W > IDX_W) begin : g_bad_hist
         $error("btb_predictor: HIST_W must lie in 1..IDX_W");
      end
   endgenerate

   logic [HIST_W-1:0] hist;
   logic [IDX_W-1:0]  lk_idx, lk_cidx, up_idx, up_cidx;
   logic [TAG_W-1:0]  lk_tag, up_tag;
   logic [PC_W-1:0]   lk_target;
   logic              lk_hit, lk_taken;

   btb_index #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W), .USE_GHR(USE_GHR)) u_lk_index (
      .pc(fetch_pc), .hist(hist), .idx(lk_idx), .cidx(lk_cidx), .tag(lk_tag)
   );

   btb_index #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W), .USE_GHR(USE_GHR)) u_up_index (
      .pc(upd_pc), .hist(hist), .idx(up_idx), .cidx(up_cidx), .tag(up_tag)
   );

   btb_history #(.HIST_W(HIST_W), .USE_GHR(USE_GHR)) u_history (
      .clk(clk), .rst_n(rst_n), .shift_en(upd_valid), .outcome(upd_taken), .hist(hist)
   );

   btb_store #(.PC_W(PC_W), .IDX_W(IDX_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(lk_idx), .rd_cidx(lk_cidx), .rd_tag(lk_tag),
      .rd_hit(lk_hit), .rd_taken(lk_taken), .rd_target(lk_target),
      .wr_en(upd_valid), .wr_idx(up_idx), .wr_cidx(up_cidx), .wr_tag(up_tag),
      .wr_taken(upd_taken), .wr_target(upd_target)
   );

   assign pred_hit     = lk_hit;
   assign pred_taken   = lk_taken;
   assign pred_next_pc = lk_taken ? lk_target : fetch_pc + PC_W'(4);

endmodule

// File: rtl/btb_predictor_checker.sv
module btb_predictor_checker #(
   parameter int PC_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic [PC_W-1:0] fetch_pc,
   input logic            pred_hit,
   input logic            pred_taken,
   input logic [PC_W-1:0] pred_next_pc,
   input logic            upd_valid,
   input logic [PC_W-1:0] upd_pc,
   input logic            upd_taken
);

   logic seen_taken_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       seen_taken_q <= 1'b0;
      else if (upd_valid && upd_taken)  seen_taken_q <= 1'b1;
   end

   AST_TAKEN_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      pred_taken |-> pred_hit); // R3

   AST_FALLTHROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      !pred_taken |-> (pred_next_pc == fetch_pc + PC_W'(4))); // R4

   AST_COLD_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_taken_q |-> !pred_hit); // R1

   AST_ALLOC_HITS: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && upd_taken) |=>
         ((fetch_pc[PC_W-1:2] != $past(upd_pc[PC_W-1:2])) || pred_hit)); // R6

   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_valid |=> (!$stable(fetch_pc) || $stable(pred_next_pc))); // R9

endmodule

bind btb_predictor btb_predictor_checker #(.PC_W(PC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_hit(pred_hit),
   .pred_taken(pred_taken), .pred_next_pc(pred_next_pc), .upd_valid(upd_valid),
   .upd_pc(upd_pc), .upd_taken(upd_taken)
);

// File: tb/btb_predictor_bench.sv
module btb_predictor_bench;

   localparam int CLK_PERIOD = 10;
   localparam int PC_W   = 32;
   localparam int IDX_W  = 10;
   localparam int HIST_W = 4;
   localparam int TAG_W  = PC_W - IDX_W - 2;
   localparam int ENT    = 1 << IDX_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [PC_W-1:0] fetch_pc = '0;
   logic upd_valid = 1'b0, upd_taken = 1'b0;
   logic [PC_W-1:0] upd_pc = '0, upd_target = '0;

   logic            p_hit  [2];
   logic            p_tk   [2];
   logic [PC_W-1:0] p_next [2];

   always #(CLK_PERIOD/2) clk = ~clk;

   // plain-index instance (mode 0)
   btb_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W), .USE_GHR(1'b0)) u_btb_predictor (
      .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
      .pred_hit(p_hit[0]), .pred_taken(p_tk[0]), .pred_next_pc(p_next[0]),
      .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_target(upd_target), .upd_taken(upd_taken)
   );

   // history-hashed instance (mode 1)
   btb_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W), .USE_GHR(1'b1)) u_btb_predictor_gs (
      .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
      .pred_hit(p_hit[1]), .pred_taken(p_tk[1]), .pred_next_pc(p_next[1]),
      .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_target(upd_target), .upd_taken(upd_taken)
   );

   // ---------------- reference model ----------------
   logic             m_v [2][ENT];
   logic [TAG_W-1:0] m_t [2][ENT];
   logic [PC_W-1:0]  m_g [2][ENT];
   logic [1:0]       m_c [2][ENT];
   logic [HIST_W-1:0] m_h;

   function automatic logic [IDX_W-1:0] f_idx(input logic [PC_W-1:0] pc);
      return pc[IDX_W+1:2];
   endfunction

   function automatic logic [IDX_W-1:0] f_cidx(input int m, input logic [PC_W-1:0] pc);
      return (m == 1) ? (pc[IDX_W+1:2] ^ {{(IDX_W-HIST_W){1'b0}}, m_h}) : pc[IDX_W+1:2];
   endfunction

   function automatic logic f_hit(input int m, input logic [PC_W-1:0] pc);
      return m_v[m][f_idx(pc)] && (m_t[m][f_idx(pc)] == pc[PC_W-1:IDX_W+2]);
   endfunction

   task automatic model_reset();
      for (int m = 0; m < 2; m++)
         for (int i = 0; i < ENT; i++) begin
            m_v[m][i] = 1'b0;
            m_c[m][i] = 2'd1;
         end
      m_h = '0;
   endtask

   task automatic model_update(input logic [PC_W-1:0] pc, input logic [PC_W-1:0] tgt, input logic tk);
      for (int m = 0; m < 2; m++) begin
         logic h;
         logic [IDX_W-1:0] i, c;
         h = f_hit(m, pc);
         i = f_idx(pc);
         c = f_cidx(m, pc);
         if (tk) begin
            m_v[m][i] = 1'b1;
            m_t[m][i] = pc[PC_W-1:IDX_W+2];
            m_g[m][i] = {tgt[PC_W-1:2], 2'b00};
            m_c[m][c] = h ? ((m_c[m][c] == 2'd3) ? 2'd3 : m_c[m][c] + 2'd1) : 2'd2;
         end else if (h) begin
            m_c[m][c] = (m_c[m][c] == 2'd0) ? 2'd0 : m_c[m][c] - 2'd1;
         end
      end
      m_h = {m_h[HIST_W-2:0], tk};
   endtask

   // ---------------- scoreboard ----------------
   typedef struct {
      logic            hit  [2];
      logic            tk   [2];
      logic [PC_W-1:0] nxt  [2];
      string           rq;
   } exp_t;

   exp_t exp_q [$];
   int n_cmp = 0;
   int n_bad = 0;

   task automatic chk(input string rq, input string what, input logic [PC_W-1:0] act,
                      input logic [PC_W-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   // driver: one cycle of lookup plus optional resolution
   task automatic step(input logic [PC_W-1:0] pc, input logic uv, input logic [PC_W-1:0] upc,
                       input logic utk, input logic [PC_W-1:0] utgt, input string rq);
      exp_t e;
      @(posedge clk);
      #1;
      fetch_pc   = pc;
      upd_valid  = uv;
      upd_pc     = upc;
      upd_taken  = utk;
      upd_target = utgt;
      for (int m = 0; m < 2; m++) begin
         e.hit[m] = f_hit(m, pc);
         e.tk[m]  = e.hit[m] && m_c[m][f_cidx(m, pc)][1];
         e.nxt[m] = e.tk[m] ? m_g[m][f_idx(pc)] : pc + 32'd4;
      end
      e.rq = rq;
      exp_q.push_back(e);
      if (uv) model_update(upc, utgt, utk);   // R11: takes effect for later lookups
   endtask

   task automatic look(input logic [PC_W-1:0] pc, input string rq);
      step(pc, 1'b0, '0, 1'b0, '0, rq);
   endtask

   task automatic resolve(input logic [PC_W-1:0] pc, input logic tk, input logic [PC_W-1:0] tgt,
                          input string rq);
      step(pc, 1'b1, pc, tk, tgt, rq);
   endtask

   // monitor: mid-cycle comparison against the queue
   initial begin
      forever begin
         @(negedge clk);
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            for (int m = 0; m < 2; m++) begin
               chk(e.rq, (m == 0) ? "next_pc plain" : "next_pc hashed", p_next[m], e.nxt[m]);
               chk(e.rq, (m == 0) ? "hit plain" : "hit hashed", {31'd0, p_hit[m]}, {31'd0, e.hit[m]});
               chk(e.rq, (m == 0) ? "taken plain" : "taken hashed", {31'd0, p_tk[m]}, {31'd0, e.tk[m]});
            end
         end
      end
   end

   task automatic do_reset();
      @(posedge clk);
      #1;
      upd_valid = 1'b0;
      rst_n = 1'b0;
      model_reset();
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      @(posedge clk);
      #1;
      upd_valid = 1'b0;
      repeat (2) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   localparam logic [PC_W-1:0] BR_A   = 32'h001CA810;
   localparam logic [PC_W-1:0] BR_AL  = 32'h002CA810;
   localparam logic [PC_W-1:0] BR_CNT = 32'h00001000;
   localparam logic [PC_W-1:0] BR_LP  = 32'h00002040;
   localparam logic [PC_W-1:0] BR_ALT = 32'h00003080;

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;

      // R1: cold table
      look(BR_A, "R1");
      look(32'h00000104, "R1");
      look(32'h12345678, "R1");

      // R11: resolution and lookup of the same branch in one cycle sees the old table
      step(BR_A, 1'b1, BR_A, 1'b1, 32'h001CA818, "R11");
      // R6, R4, R2: allocated entry predicts its target; index 0x204 tag 0x001CA
      look(BR_A, "R6");
      @(negedge clk);
      chk("R2", "literal target", p_next[0], 32'h001CA818);
      look(BR_A | 32'h3, "R2");             // low bits ignored
      look(BR_A + 32'h1000, "R2");          // neighbouring tag misses

      // R3: alias at same index with another tag
      look(BR_AL, "R3");
      resolve(BR_AL, 1'b1, 32'h002CA900, "R3");
      look(BR_AL, "R3");
      look(BR_A, "R3");

      // R8: not-taken miss allocates nothing
      resolve(32'h00000400, 1'b0, 32'h00000800, "R8");
      look(32'h00000400, "R8");

      // R9: update fields without valid are ignored
      step(32'h00000500, 1'b0, 32'h00000500, 1'b1, 32'h00000900, "R9");
      look(32'h00000500, "R9");

      // R5: counter walk on one branch
      resolve(BR_CNT, 1'b1, 32'h00000F00, "R5");
      look(BR_CNT, "R5");
      resolve(BR_CNT, 1'b0, 32'h00000F00, "R5");
      look(BR_CNT, "R5");
      resolve(BR_CNT, 1'b0, 32'h00000F00, "R5");
      resolve(BR_CNT, 1'b0, 32'h00000F00, "R5");
      look(BR_CNT, "R5");
      for (int k = 0; k < 5; k++) resolve(BR_CNT, 1'b1, 32'h00000F00, "R5");
      resolve(BR_CNT, 1'b0, 32'h00000F00, "R5");
      look(BR_CNT, "R5");

      // R7: taken hit replaces target
      resolve(BR_CNT, 1'b1, 32'h00000E00, "R7");
      look(BR_CNT, "R7");

      // R10: loop branch, seven taken then exit, four trips
      for (int t = 0; t < 4; t++)
         for (int k = 0; k < 8; k++)
            step(BR_LP, 1'b1, BR_LP, (k != 7), 32'h00002000, "R10");

      // R10, R5: alternating outcomes
      for (int k = 0; k < 16; k++)
         step(BR_ALT, 1'b1, BR_ALT, k[0] == 1'b0, 32'h00003100, "R10");
      look(BR_ALT, "R10");

      // R1: a second reset clears everything
      do_reset();
      look(BR_A, "R1");
      look(BR_LP, "R1");

      finish_run();
   end

endmodule